// File: doc/BRIEF.md
# Vector Macro-Instruction Iteration Controller

This block takes one wide macro-instruction that describes a whole vector or matrix-vector operation and turns it into a sequence of per-cycle issue beats for a row of parallel arithmetic tracks. Software never writes a loop. The controller loads length and width counters from the instruction. It then steps through the elements in groups of `NTRACK` per beat and produces a lane-valid mask, operand addresses for `x` and `y`, and a result address for `z`. When the final beat goes out, it signals that the next instruction may be taken. Because the step size comes from the hardware parameter `NTRACK`, the same instruction stream runs unchanged on a controller built with any number of tracks.

Two iteration styles exist. In vector style, one beat covers `NTRACK` consecutive elements, and the final beat masks off the lanes that fall past the end. In matrix-vector style, the matrix has Width rows and Length columns and is stored row-major. It is processed in column tiles `NTRACK` wide. Within a tile, every row gets one beat before the controller moves to the next tile. Each beat carries a first-tile flag, which tells the datapath to start its partial sum from zero. It also carries a last-tile flag, which enables the write of finished sums to `z`. The arithmetic datapath and the memories lie outside this block.

The sequencer has four states. In IDLE the block is ready, and an accepted instruction moves it to VEC_RUN, MAT_RUN or EMPTY. VEC_RUN returns to IDLE on its final beat. MAT_RUN returns to IDLE on the final row of the final tile. EMPTY always returns to IDLE after one cycle. A stall holds every state and counter in place.

Top module: `vic_top`

## Requirements
- R1: The 128-bit instruction word is decoded as follows: operation code in bits 127:124, Length in 123:110, Width in 109:96, `x` base in 95:64, `y` base in 63:32 and `z` base in 31:0. `op_mode` shows the operation code on every issue beat.
- R2: `instr_ready` is high only in IDLE, and an instruction is accepted only when `instr_valid` and `instr_ready` are both high. `instr_valid` has no effect while an instruction is running.
- R3: Any operation code other than 4'b0111 selects vector style. It produces ceil(Length/NTRACK) beats, and beat k has column offset c = k*NTRACK, with `addr_x` = x+c, `addr_y` = y+c and `addr_z` = z+c.
- R4: On every beat, lane i of `lane_valid` is high exactly when c+i < Length. All beats except the final column group therefore have a full mask.
- R5: `instr_done` is high on the final beat of an instruction, and `instr_ready` is high on the following cycle.
- R6: Operation code 4'b0111 selects matrix-vector style. It produces ceil(Length/NTRACK) column tiles of Width beats each. Tiles are taken in increasing column order, and within a tile the rows are taken in increasing row order 0..Width-1.
- R7: In matrix-vector style, the beat for row r and column offset c carries `addr_x` = x + r*Length + c, `addr_y` = y + c and `addr_z` = z + r.
- R8: `tile_first` is high on the beats whose column offset is 0. `tile_last` is high on the beats of the final column group, where c+NTRACK >= Length.
- R9: While `stall` is high, `issue_valid` is low and nothing advances. The next unstalled beat is the one that was pending.
- R10: An instruction with Length 0, or a matrix-vector instruction with Width 0, produces no beat. It raises `instr_done` on the cycle after acceptance.
- R11: After reset, `instr_ready` is high and `issue_valid` and `instr_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is present |
| instr_word | input | 128 | Macro-instruction |
| stall | input | 1 | Holds issue for this cycle |
| instr_ready | output | 1 | Controller can accept an instruction |
| issue_valid | output | 1 | A beat is issued this cycle |
| op_mode | output | 4 | Operation code of the running instruction |
| lane_valid | output | NTRACK | Per-lane valid mask for the beat |
| addr_x | output | 32 | Address of lane 0 of the x operand |
| addr_y | output | 32 | Address of lane 0 of the y operand |
| addr_z | output | 32 | Result address |
| tile_first | output | 1 | Beat belongs to column offset 0 |
| tile_last | output | 1 | Beat belongs to the final column group |
| instr_done | output | 1 | Instruction retires this cycle |

## Verification
The embedded assertions check the following on every cycle: ready and issue are never high together, a stall blocks issue and freezes the counters, retirement is followed by readiness, the EMPTY state retires without a beat, lane 0 is valid on every beat, and only the final column group carries a partial mask. The correct beat count, the tile-major and row-minor order, and the exact row-major addresses appear only in the bench's sweeps. These sweeps cover lengths on both sides of multiples of the track count, widths down to zero, stall patterns and instruction noise while the block is busy. Each case is compared against sequences that the bench computes arithmetically.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int MODE_W  = 4;
    localparam int LEN_W   = 14;
    localparam int ADDR_W  = 32;
    localparam int INSTR_W = MODE_W + 2 * LEN_W + 3 * ADDR_W;
    localparam int OFF_W   = 2 * LEN_W;
    localparam logic [MODE_W-1:0] MATVEC_CODE = 4'b0111;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  wid;
        logic [ADDR_W-1:0] ax;
        logic [ADDR_W-1:0] ay;
        logic [ADDR_W-1:0] az;
    } macro_t;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_VEC_RUN = 2'd1,
        S_MAT_RUN = 2'd2,
        S_EMPTY   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/vic_decode.sv
module vic_decode
    import vic_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output macro_t             fields,
    output logic               is_matvec,
    output logic               is_empty
);
    always_comb begin
        fields    = macro_t'(word);
        is_matvec = (fields.mode == MATVEC_CODE);
        is_empty  = (fields.len == '0) || (is_matvec && fields.wid == '0);
    end
endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int NTRACK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  macro_t            dec,
    input  logic              dec_matvec,
    input  logic              dec_empty,
    input  logic              stall,
    output macro_t            cur,
    output logic              in_matvec,
    output logic [LEN_W-1:0]  rem_len,
    output logic [LEN_W-1:0]  col_base,
    output logic [LEN_W-1:0]  row_idx,
    output logic [OFF_W-1:0]  row_off,
    output logic              ready,
    output logic              issue,
    output logic              done,
    output logic              first_tile,
    output logic              last_tile
);
    localparam logic [LEN_W:0]   NT_EXT = (LEN_W+1)'(NTRACK);
    localparam logic [LEN_W-1:0] NT     = LEN_W'(NTRACK);
    localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

    seq_state_t state, nxt;
    logic [LEN_W-1:0] rem_wid, wid_copy;
    logic accept, last_col, row_last;

    assign accept   = instr_valid && ready;
    assign last_col = ({1'b0, rem_len} <= NT_EXT);
    assign row_last = (rem_wid == ONE);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    if (dec_empty)       nxt = S_EMPTY;
                    else if (dec_matvec) nxt = S_MAT_RUN;
                    else                 nxt = S_VEC_RUN;
                end
            end
            S_VEC_RUN: if (issue && last_col) nxt = S_IDLE;
            S_MAT_RUN: if (issue && last_col && row_last) nxt = S_IDLE;
            S_EMPTY:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= '0;
            rem_len  <= '0;
            rem_wid  <= '0;
            wid_copy <= '0;
            col_base <= '0;
            row_idx  <= '0;
            row_off  <= '0;
        end else if (accept) begin
            cur      <= dec;
            rem_len  <= dec.len;
            rem_wid  <= dec.wid;
            wid_copy <= dec.wid;
            col_base <= '0;
            row_idx  <= '0;
            row_off  <= '0;
        end else if (issue) begin
            if (state == S_VEC_RUN) begin
                rem_len  <= rem_len - NT;
                col_base <= col_base + NT;
            end else if (row_last) begin
                rem_len  <= rem_len - NT;
                col_base <= col_base + NT;
                rem_wid  <= wid_copy;
                row_idx  <= '0;
                row_off  <= '0;
            end else begin
                rem_wid  <= rem_wid - ONE;
                row_idx  <= row_idx + ONE;
                row_off  <= row_off + OFF_W'(cur.len);
            end
        end
    end

    always_comb begin
        ready      = (state == S_IDLE);
        in_matvec  = (state == S_MAT_RUN);
        issue      = ((state == S_VEC_RUN) || (state == S_MAT_RUN)) && !stall;
        done       = (state == S_EMPTY) ||
                     (issue && last_col && ((state == S_VEC_RUN) || row_last));
        first_tile = issue && (col_base == '0);
        last_tile  = issue && last_col;
    end

    a_r2_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && issue));
    a_r9_stall_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue);
    a_r9_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !ready) |=> ($stable(col_base) && $stable(rem_wid) && $stable(row_off)));
    a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    a_r10_empty_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EMPTY) |-> (done && !issue));
endmodule

// File: rtl/vic_lanes.sv
module vic_lanes
    import vic_pkg::*;
#(
    parameter int NTRACK = 4
) (
    input  logic [LEN_W-1:0]  rem_len,
    input  logic              issue,
    output logic [NTRACK-1:0] lane_valid
);
    for (genvar i = 0; i < NTRACK; i++) begin : g_lane
        assign lane_valid[i] = issue && ({1'b0, rem_len} > (LEN_W+1)'(i));
    end
endmodule

// File: rtl/vic_agen.sv
module vic_agen
    import vic_pkg::*;
(
    input  macro_t            cur,
    input  logic              in_matvec,
    input  logic [LEN_W-1:0]  col_base,
    input  logic [LEN_W-1:0]  row_idx,
    input  logic [OFF_W-1:0]  row_off,
    output logic [ADDR_W-1:0] addr_x,
    output logic [ADDR_W-1:0] addr_y,
    output logic [ADDR_W-1:0] addr_z
);
    logic [ADDR_W-1:0] col_ext;

    always_comb begin
        col_ext = ADDR_W'(col_base);
        addr_y  = cur.ay + col_ext;
        if (in_matvec) begin
            addr_x = cur.ax + ADDR_W'(row_off) + col_ext;
            addr_z = cur.az + ADDR_W'(row_idx);
        end else begin
            addr_x = cur.ax + col_ext;
            addr_z = cur.az + col_ext;
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NTRACK = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr_word,
    input  logic               stall,
    output logic               instr_ready,
    output logic               issue_valid,
    output logic [MODE_W-1:0]  op_mode,
    output logic [NTRACK-1:0]  lane_valid,
    output logic [ADDR_W-1:0]  addr_x,
    output logic [ADDR_W-1:0]  addr_y,
    output logic [ADDR_W-1:0]  addr_z,
    output logic               tile_first,
    output logic               tile_last,
    output logic               instr_done
);
    macro_t dec, cur;
    logic dec_matvec, dec_empty, in_matvec;
    logic [LEN_W-1:0] rem_len, col_base, row_idx;
    logic [OFF_W-1:0] row_off;

    vic_decode u_dec (
        .word      (instr_word),
        .fields    (dec),
        .is_matvec (dec_matvec),
        .is_empty  (dec_empty)
    );

    vic_seq #(.NTRACK(NTRACK)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .dec        (dec),
        .dec_matvec (dec_matvec),
        .dec_empty  (dec_empty),
        .stall      (stall),
        .cur        (cur),
        .in_matvec  (in_matvec),
        .rem_len    (rem_len),
        .col_base   (col_base),
        .row_idx    (row_idx),
        .row_off    (row_off),
        .ready      (instr_ready),
        .issue      (issue_valid),
        .done       (instr_done),
        .first_tile (tile_first),
        .last_tile  (tile_last)
    );

    vic_lanes #(.NTRACK(NTRACK)) u_lanes (
        .rem_len    (rem_len),
        .issue      (issue_valid),
        .lane_valid (lane_valid)
    );

    vic_agen u_agen (
        .cur       (cur),
        .in_matvec (in_matvec),
        .col_base  (col_base),
        .row_idx   (row_idx),
        .row_off   (row_off),
        .addr_x    (addr_x),
        .addr_y    (addr_y),
        .addr_z    (addr_z)
    );

    assign op_mode = cur.mode;

    a_r4_lane0_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> lane_valid[0]);
    a_r4_full_mask_early: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !tile_last) |-> (&lane_valid));
    a_r8_last_holds_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_done && issue_valid) |-> tile_last);
    a_r11_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (lane_valid == '0));
endmodule

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [127:0] instr_word = '0;
    logic         stall = 1'b0;
    logic         instr_ready, issue_valid, tile_first, tile_last, instr_done;
    logic [3:0]   op_mode;
    logic [N-1:0] lane_valid;
    logic [31:0]  addr_x, addr_y, addr_z;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int stall_ctr = 0;
    bit finished = 1'b0;

    vic_top #(.NTRACK(N)) uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .stall(stall), .instr_ready(instr_ready), .issue_valid(issue_valid),
        .op_mode(op_mode), .lane_valid(lane_valid), .addr_x(addr_x), .addr_y(addr_y),
        .addr_z(addr_z), .tile_first(tile_first), .tile_last(tile_last),
        .instr_done(instr_done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] mode, input int len, input int wid,
                       input logic [31:0] ax, input logic [31:0] ay, input logic [31:0] az,
                       input bit use_stall, input bit noise);
        bit mat;
        int tiles, total;
        logic [127:0] w;
        mat   = (mode == 4'b0111);
        tiles = (len + N - 1) / N;
        total = mat ? tiles * wid : tiles;
        w = {mode, 14'(len), 14'(wid), ax, ay, az};
        @(negedge clk);
        stall = 1'b0;
        #1;
        check("R2 ready before accept", 256'(instr_ready), 256'(1));
        instr_valid = 1'b1;
        instr_word  = w;
        if (total == 0) begin
            @(negedge clk);
            instr_valid = 1'b0;
            #1;
            check("R10 empty retires", {254'(0), instr_done, issue_valid}, 256'(2));
        end else begin
            for (int k = 0; k < total; k++) begin
                int c, r;
                logic [N-1:0] m;
                logic [31:0] ex, ey, ez;
                bit stl;
                c = mat ? (k / wid) * N : k * N;
                r = mat ? (k % wid) : 0;
                for (int i = 0; i < N; i++) m[i] = (c + i < len);
                ex = mat ? ax + 32'(r * len + c) : ax + 32'(c);
                ey = ay + 32'(c);
                ez = mat ? az + 32'(r) : az + 32'(c);
                do begin
                    @(negedge clk);
                    stall_ctr++;
                    stl = use_stall && (stall_ctr % 3 == 0);
                    stall = stl;
                    instr_valid = noise && (k != total - 1);
                    instr_word  = ~w;
                    #1;
                    if (stl) check("R9 stalled no issue", 256'(issue_valid), 256'(0));
                end while (stl);
                check(mat ? "R1 R6 R7 R8 R4 R5 matrix beat" : "R1 R3 R4 R5 R8 vector beat",
                      {issue_valid, op_mode, 4'(lane_valid), addr_x, addr_y, addr_z,
                       tile_first, tile_last, instr_done},
                      {1'b1, mode, 4'(m), ex, ey, ez,
                       (c == 0), (c + N >= len), (k == total - 1)});
            end
        end
        @(negedge clk);
        instr_valid = 1'b0;
        stall = 1'b0;
        #1;
        check("R5 R2 ready after retire", {254'(0), instr_ready, issue_valid}, 256'(2));
    endtask

    initial begin
        #1;
        check("R11 reset ready/issue/done",
              {253'(0), instr_ready, issue_valid, instr_done}, 256'(4));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R11 ready after release", 256'(instr_ready), 256'(1));

        for (int l = 0; l <= 13; l++)
            run(4'h2, l, 3, 32'h1000, 32'h2000, 32'h3000, (l % 2) == 1, 1'b0);
        run(4'hA, 9, 0, 32'hFFFF_FFF8, 32'h10, 32'h20, 1'b1, 1'b1);
        for (int l = 0; l <= 9; l++)
            for (int wd = 0; wd <= 3; wd++)
                run(4'b0111, l, wd, 32'h4000, 32'h5000, 32'h6000, (l + wd) % 2 == 0, wd == 2);
        run(4'b0111, 13, 5, 32'hFFFF_FF00, 32'h80, 32'h90, 1'b1, 1'b1);
        run(4'h0, 16383, 7, 32'h0, 32'h100000, 32'h200000, 1'b0, 1'b0);
        run(4'b0111, 16, 1, 32'h40, 32'h50, 32'h60, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule